// File: doc/BRIEF.md
# GPIO Companion Controller

A bus-attached companion peripheral holding a small bank of 16-bit control registers and a 16-line general-purpose output port. A host reaches it through a simple synchronous register interface: request, write enable, a 12-bit byte offset inside a 4 KB window, write data and registered read data. The control bank stores mode, data, power, clock and three interrupt words. A fixed status word reads back its reset value.

The GPIO section keeps a direction mask and a level register. The driven outputs are a recorded copy of level AND direction. That copy is refreshed only when the host writes the direction or the level. On each refresh, every line whose driven value moves raises a one-cycle change strobe, and all the changed lines strobe in the same cycle. External per-line inputs can set or clear level bits directly. They bypass the direction mask, and they reach the outputs only at the next host write to the direction or the level.

Top module: `gpio_companion`

## Requirements
- R1: After reset the status word reads 0x0002. Every other register reads 0, and gpio_o, chg_o and bad_addr_o are 0.
- R2: A read request (req_i=1, we_i=0) loads rdata_o at that clock edge, so the value is visible in the following cycle. rdata_o then holds until the next read. The offset map is: mode 0x00, data 0x04, status 0x08, power 0x0C, clock 0x10, interrupt request 0x14, interrupt mask 0x18, interrupt status 0x1C, direction 0x20, level 0x24 and 0x28.
- R3: A write stores only wdata_i[15:0]. A power write with bit 7 set stores the value ORed with 0x8040. Without bit 7 the value is stored unchanged.
- R4: A write to offset 0x24 or 0x28 stores the data ANDed with the direction held before the write. Both offsets read back the same level register.
- R5: gpio_o changes only in the cycle after a direction or level write. It then equals the new level AND the new direction.
- R6: In the cycle after a direction or level write, chg_o has a 1 on exactly those lines whose gpio_o value changed. chg_o is 0 in every other cycle.
- R7: An access at any other offset in the window, aligned or not, reads 0 and changes no register. It raises bad_addr_o for exactly the one following cycle.
- R8: When ext_we_i[n]=1, bit n of the level register takes ext_lvl_i[n], whatever the direction. gpio_o does not change from this alone. A host level write in the same cycle takes priority over the external inputs.
- R9: A write to the status offset 0x08 is ignored and does not raise bad_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the 4 KB window |
| wdata_i | input | 32 | Write data; only the low 16 bits are used |
| rdata_o | output | 16 | Registered read data |
| bad_addr_o | output | 1 | One-cycle pulse for an undecoded offset |
| ext_we_i | input | 16 | Per-line external level update enable |
| ext_lvl_i | input | 16 | Per-line external level value |
| gpio_o | output | 16 | Driven lines (recorded level AND direction) |
| chg_o | output | 16 | Per-line one-cycle change strobe |

## Verification
Assertions check four properties on every cycle. The driven lines never lie outside the direction mask. The outputs and change strobes stay quiet unless a direction or level write came before. A power write with bit 7 set leaves bits 15 and 6 high. An undecoded access yields zero read data and a single-cycle error pulse. The bench's scenarios are needed for the rest: the exact change-strobe pattern, masking by the direction held before a level write, external updates that stay hidden until the next write, the priority of a host write over the external inputs, and the ignored status write. The bench compares these against its reference model every cycle.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 12;
  localparam int N_LINES = 16;
  localparam int PWR_TRIG_BIT = 7;
  localparam logic [REG_W-1:0] STATUS_RST = 16'h0002;
  localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;

  // order matches the offset map: index * 4 = offset
  typedef enum logic [3:0] {
    SEL_MODE, SEL_DATA, SEL_STAT, SEL_PWR, SEL_CLK, SEL_IRR, SEL_IMR, SEL_ISR,
    SEL_DIR, SEL_LVL, SEL_NONE
  } sel_e;

  localparam int N_CTRL = 8;
endpackage

// File: rtl/gcc_decode.sv
module gcc_decode
  import gcc_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  output sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i[AW-1:2] < AW'(N_CTRL + 1)) sel_o = sel_e'(addr_i[5:2]);
      else if (addr_i[AW-1:2] == AW'(N_CTRL + 1) || addr_i[AW-1:2] == AW'(N_CTRL + 2))
        sel_o = SEL_LVL;
    end
  end
endmodule

// File: rtl/gcc_ctrl_regs.sv
module gcc_ctrl_regs
  import gcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  sel_e             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rd_o
);
  logic [REG_W-1:0] regs [N_CTRL];

  for (genvar i = 0; i < N_CTRL; i++) begin : g_reg
    if (i == int'(SEL_STAT)) begin : g_ro
      assign regs[i] = STATUS_RST;
    end else begin : g_rw
      logic [REG_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (wr_i && sel_i == sel_e'(i)) begin
          if (i == int'(SEL_PWR) && wdata_i[PWR_TRIG_BIT]) q <= wdata_i | PWR_FORCE;
          else q <= wdata_i;
        end
      end
      assign regs[i] = q;
    end
  end

  always_comb begin
    rd_o = '0;
    if (sel_i < SEL_DIR) rd_o = regs[sel_i[2:0]];
  end

  p_pwr_force_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_PWR && wdata_i[PWR_TRIG_BIT]) |=> (regs[3][15] && regs[3][6]));
endmodule

// File: rtl/gcc_gpio.sv
module gcc_gpio #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_dir_i,
  input  logic         wr_lvl_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] ext_we_i,
  input  logic [N-1:0] ext_lvl_i,
  output logic [N-1:0] dir_o,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] gpio_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] dir_q, lvl_q, out_q, chg_q;
  logic [N-1:0] lvl_ext, lvl_d, dir_d, eff_d;
  logic         upd;

  for (genvar n = 0; n < N; n++) begin : g_ext
    assign lvl_ext[n] = ext_we_i[n] ? ext_lvl_i[n] : lvl_q[n];
  end

  assign lvl_d = wr_lvl_i ? (wdata_i & dir_q) : lvl_ext;
  assign dir_d = wr_dir_i ? wdata_i : dir_q;
  assign eff_d = lvl_d & dir_d;
  assign upd   = wr_dir_i | wr_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lvl_q <= '0;
      out_q <= '0;
      chg_q <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
      chg_q <= upd ? (eff_d ^ out_q) : '0;
      if (upd) out_q <= eff_d;
    end
  end

  assign dir_o  = dir_q;
  assign lvl_o  = lvl_q;
  assign gpio_o = out_q;
  assign chg_o  = chg_q;

  p_out_in_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q & ~dir_q) == '0);
  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(out_q));
  p_chg_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> chg_q == '0);
endmodule

// File: rtl/gpio_companion.sv
module gpio_companion
  import gcc_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int N     = N_LINES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              bad_addr_o,
  input  logic [N-1:0]      ext_we_i,
  input  logic [N-1:0]      ext_lvl_i,
  output logic [N-1:0]      gpio_o,
  output logic [N-1:0]      chg_o
);
  sel_e             sel;
  logic             wr, rd;
  logic [REG_W-1:0] wdat, ctrl_rd, dir_ext, lvl_ext, rd_mux, rdata_q;
  logic [N-1:0]     dir, lvl;
  logic             bad_q;
  logic             unused_hi;

  assign wdat      = wdata_i[REG_W-1:0];
  assign unused_hi = ^wdata_i[BUS_W-1:REG_W];
  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;

  gcc_decode #(.AW(ADDR_W)) i_dec (.addr_i(addr_i), .sel_o(sel));

  gcc_ctrl_regs i_ctrl (
    .clk_i, .rst_ni, .wr_i(wr), .sel_i(sel), .wdata_i(wdat), .rd_o(ctrl_rd)
  );

  gcc_gpio #(.N(N)) i_gpio (
    .clk_i, .rst_ni,
    .wr_dir_i (wr && sel == SEL_DIR),
    .wr_lvl_i (wr && sel == SEL_LVL),
    .wdata_i  (wdat[N-1:0]),
    .ext_we_i, .ext_lvl_i,
    .dir_o    (dir),
    .lvl_o    (lvl),
    .gpio_o, .chg_o
  );

  always_comb begin
    dir_ext = '0;
    lvl_ext = '0;
    dir_ext[N-1:0] = dir;
    lvl_ext[N-1:0] = lvl;
    case (sel)
      SEL_DIR:  rd_mux = dir_ext;
      SEL_LVL:  rd_mux = lvl_ext;
      default:  rd_mux = ctrl_rd;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= req_i && sel == SEL_NONE;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o    = rdata_q;
  assign bad_addr_o = bad_q;

  p_bad_rdata_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_NONE) |=> (rdata_o == '0 && bad_addr_o));
  p_bad_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !bad_addr_o);
endmodule

// File: tb/test_gpio_companion.sv
module test_gpio_companion;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] ext_we = '0, ext_lvl = '0;
  logic [15:0] rdata, gpio, chg;
  logic        bad;

  int vectors = 0, miscompares = 0;

  // reference state
  int unsigned m_reg [int];
  logic [15:0] m_dir = 0, m_lvl = 0, m_out = 0, m_chg = 0, m_rd = 0;
  logic        m_bad = 0;

  always #5 clk = ~clk;

  gpio_companion i_gpio_companion (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .bad_addr_o(bad),
    .ext_we_i(ext_we), .ext_lvl_i(ext_lvl), .gpio_o(gpio), .chg_o(chg)
  );

  function automatic bit known(int a);
    return (a % 4 == 0) && a <= 'h28;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(bit r, bit w, int a, logic [15:0] d, logic [15:0] ew, logic [15:0] el);
    logic [15:0] nl;
    bit upd = 0;
    nl = m_lvl;
    for (int n = 0; n < 16; n++) if (ew[n]) nl[n] = el[n];
    m_bad = r && !known(a);
    m_chg = 0;
    if (r && !w) begin
      if (!known(a)) m_rd = 0;
      else if (a == 'h08) m_rd = 16'h0002;
      else if (a == 'h20) m_rd = m_dir;
      else if (a == 'h24 || a == 'h28) m_rd = m_lvl;
      else m_rd = 16'(m_reg[a]);
    end
    if (r && w && known(a)) begin
      if (a == 'h20) begin m_dir = d; upd = 1; end
      else if (a == 'h24 || a == 'h28) begin nl = d & m_dir; upd = 1; end
      else if (a == 'h0C) m_reg[a] = d[7] ? (d | 16'h8040) : d;
      else if (a != 'h08) m_reg[a] = d;
    end
    m_lvl = nl;
    if (upd) begin
      m_chg = (m_lvl & m_dir) ^ m_out;
      m_out = m_lvl & m_dir;
    end
  endtask

  task automatic step(string tag, bit r, bit w, int a, logic [31:0] d,
                      logic [15:0] ew = 0, logic [15:0] el = 0);
    req = r; we = w; addr = 12'(a); wdata = d; ext_we = ew; ext_lvl = el;
    @(posedge clk);
    model(r, w, a, d[15:0], ew, el);
    @(negedge clk);
    req = 0; we = 0; ext_we = 0;
    chk(tag, "rdata", rdata, m_rd);
    chk(tag, "gpio", gpio, m_out);
    chk(tag, "chg", chg, m_chg);
    chk(tag, "bad", {15'b0, bad}, {15'b0, m_bad});
  endtask

  task automatic wr(string tag, int a, logic [31:0] d); step(tag, 1, 1, a, d); endtask
  task automatic rd_(string tag, int a); step(tag, 1, 0, a, 0); endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=done", vectors);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int a = 0; a <= 'h1C; a += 4) m_reg[a] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a <= 'h28; a += 4) rd_("R1", a);
    // R2 offset map, R3 truncation
    for (int a = 0; a <= 'h1C; a += 4) wr("R3", a, 32'hABCD_0000 | 32'(a * 'h111 + 5));
    for (int a = 0; a <= 'h1C; a += 4) rd_("R2", a);
    // R9 status write ignored
    wr("R9", 'h08, 32'hFFFF);
    rd_("R9", 'h08);
    // R3 power forcing
    wr("R3", 'h0C, 32'h0080); rd_("R3", 'h0C);
    wr("R3", 'h0C, 32'h1234_0001); rd_("R3", 'h0C);
    wr("R3", 'h0C, 32'h00FF); rd_("R3", 'h0C);
    // R4 masking, R5/R6 outputs and strobes
    wr("R4", 'h24, 32'hFFFF); rd_("R4", 'h28);
    wr("R6", 'h20, 32'h00FF);
    wr("R6", 'h24, 32'hFFFF); rd_("R4", 'h24); rd_("R4", 'h28);
    wr("R6", 'h20, 32'h0F0F);
    wr("R5", 'h28, 32'h0A0A); rd_("R4", 'h24);
    step("R5", 0, 0, 0, 0);
    // R8 external inputs, hidden until next write
    step("R8", 0, 0, 0, 0, 16'h8003, 16'h8002);
    rd_("R8", 'h24);
    wr("R8", 'h20, 32'hFFFF);
    step("R8", 1, 1, 'h24, 32'h00F0, 16'h0F00, 16'h0F00);
    rd_("R8", 'h28);
    step("R8", 1, 0, 'h20, 0, 16'h0001, 16'h0001);
    rd_("R8", 'h24);
    // R7 undecoded offsets
    rd_("R7", 'h2C); rd_("R7", 'h001); rd_("R7", 'hFFC);
    wr("R7", 'h2C, 32'h5555); wr("R7", 'h003, 32'h5555); wr("R7", 'h022, 32'h5555);
    rd_("R7", 'h20); rd_("R7", 'h00);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % 'h1000) : int'(($urandom % 12) * 4);
      step("R2", 1'($urandom), 1'($urandom), a, $urandom,
           ($urandom % 3 == 0) ? 16'($urandom) : 16'h0, 16'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule